// File: doc/BRIEF.md
# Dual-Mode Bi-Phase Line Encoder

This block turns a stream of single data bits into a self-clocking serial line signal. It can use either FM0 (bi-phase space) code or Manchester code. The block runs from a clock at twice the bit rate. Each bit therefore takes two clock cycles: a first half and a second half. An internal phase flag records which half is being sent.

Data bits arrive through a valid/ready handshake. The block raises ready only at a bit boundary. The mode input is sampled together with each accepted bit, so a change of scheme only takes effect between bits. Both schemes share one stored-level flip-flop and one level generator. The generator uses a single XOR path for both codes:
- In FM0 mode, the stored level is the second-half level of the previous bit.
- In Manchester mode, the stored level is held at zero.

A flip-flop drives the line, so the output does not glitch.

Top module: `biphase_line_enc`

## Requirements
- R1: While reset is active, and after it is released, the line output is low, in_ready is high and the stored FM0 level is zero.
- R2: The enc_mode value presented with an accepted bit selects that bit's code: 0 gives FM0 and 1 gives Manchester.
- R3: In Manchester mode, a data 1 is sent as high in the first half and low in the second half. A data 0 is sent as low then high, so every bit inverts at mid-bit.
- R4: In FM0 mode, the line level in the first half of every bit is the inverse of the level that ended the previous FM0 bit.
- R5: In FM0 mode, a data 0 inverts the line again at mid-bit, and a data 1 keeps the first-half level through the second half.
- R6: The stored FM0 level starts at zero. It is also zero after any Manchester bit or after a change of mode. An FM0 bit sent from that state has a high first half.
- R7: in_ready is high only at a bit boundary. A bit is accepted on a rising edge where in_valid and in_ready are both high. Its first-half level appears on the line in the cycle after that edge, and its second-half level appears one cycle later. in_ready is low for exactly one cycle after an acceptance.
- R8: When no valid bit is offered at a boundary, the line holds its current level and the stored FM0 level does not change. The next FM0 bit still inverts the line at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A data bit is offered |
| in_data | input | 1 | Data bit to encode |
| enc_mode | input | 1 | Selects the code: 0 for FM0, 1 for Manchester; sampled with the bit |
| in_ready | output | 1 | High at a bit boundary, when a new bit can be accepted |
| line_out | output | 1 | Registered serial line level |

## Verification
The bench checks the line level in every half-bit against a model that follows the requirements, with no other information about the design.

The stimulus covers:
- runs of equal bits in both modes, where a missing boundary inversion in FM0 or a missing mid-bit inversion in Manchester would show up;
- idle gaps between FM0 bits, where a design that loses or corrupts the stored level would get the next boundary inversion wrong;
- switches from Manchester back to FM0, where a stale stored level would give the first FM0 bit a low first half;
- a long pseudo-random stream that changes mode often.

// File: rtl/biphase_enc_pkg.sv
package biphase_enc_pkg;

    typedef enum logic {
        CODE_FM0 = 1'b0,
        CODE_MAN = 1'b1
    } code_sel_e;

    typedef struct packed {
        code_sel_e code;
        logic      bit_val;
        logic      held_lvl;
        logic      line;
    } enc_regs_t;

endpackage

// File: rtl/biphase_phase_ctrl.sv
module biphase_phase_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic ready,
    output logic accept,
    output logic second_half
);
    logic phase_d, phase_q;

    assign ready       = ~phase_q;
    assign accept      = in_valid & ~phase_q;
    assign second_half = phase_q;

    always_comb begin
        phase_d = phase_q;
        if (accept) begin
            phase_d = 1'b1;
        end else if (phase_q) begin
            phase_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    // R7: after an acceptance, the block is busy for exactly one cycle
    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!ready ##1 ready));
endmodule

// File: rtl/biphase_level_gen.sv
module biphase_level_gen
    import biphase_enc_pkg::*;
(
    input  code_sel_e code,
    input  logic      bit_val,
    input  logic      prev_lvl,
    output logic      first_lvl,
    output logic      second_lvl
);
    logic prev_eff;
    logic xor_path;

    always_comb begin
        prev_eff   = (code == CODE_MAN) ? 1'b0 : prev_lvl;
        xor_path   = bit_val ^ prev_eff;
        first_lvl  = (code == CODE_MAN) ? bit_val : ~prev_eff;
        second_lvl = xor_path ^ (code == CODE_MAN);
    end
endmodule

// File: rtl/biphase_line_enc.sv
module biphase_line_enc
    import biphase_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_data,
    input  logic enc_mode,
    output logic in_ready,
    output logic line_out
);
    enc_regs_t regs_d, regs_q;
    logic      accept, second_half;
    code_sel_e gen_code;
    logic      gen_bit, gen_prev, gen_first, gen_second;

    biphase_phase_ctrl u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .ready       (in_ready),
        .accept      (accept),
        .second_half (second_half)
    );

    // One shared generator: fed by the incoming bit at a boundary,
    // and by the stored bit during the second half
    always_comb begin
        gen_code = second_half ? regs_q.code : code_sel_e'(enc_mode);
        gen_bit  = second_half ? regs_q.bit_val : in_data;
        gen_prev = regs_q.held_lvl;
        if (!second_half && (code_sel_e'(enc_mode) != regs_q.code)) begin
            gen_prev = 1'b0;
        end
    end

    biphase_level_gen u_gen (
        .code       (gen_code),
        .bit_val    (gen_bit),
        .prev_lvl   (gen_prev),
        .first_lvl  (gen_first),
        .second_lvl (gen_second)
    );

    always_comb begin
        regs_d = regs_q;
        if (accept) begin
            regs_d.code    = code_sel_e'(enc_mode);
            regs_d.bit_val = in_data;
            regs_d.line    = gen_first;
            if (code_sel_e'(enc_mode) != regs_q.code) regs_d.held_lvl = 1'b0;
        end else if (second_half) begin
            regs_d.line     = gen_second;
            regs_d.held_lvl = (regs_q.code == CODE_MAN) ? 1'b0 : gen_second;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{code: CODE_FM0, bit_val: 1'b0, held_lvl: 1'b0, line: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign line_out = regs_q.line;

    // R3: Manchester always inverts at mid-bit
    assert_man_mid_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (second_half && regs_q.code == CODE_MAN) |=> (line_out != $past(line_out)));
    // R4: each accepted FM0 bit inverts the line at its start
    assert_fm0_edge_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !enc_mode && !regs_q.code && !second_half) |=> (line_out != $past(line_out)));
    // R5: an FM0 one keeps its level through the bit
    assert_fm0_one_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (second_half && regs_q.code == CODE_FM0 && regs_q.bit_val) |=> $stable(line_out));
    // R6: Manchester leaves the stored level cleared
    assert_man_clears_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (second_half && regs_q.code == CODE_MAN) |=> (regs_q.held_lvl == 1'b0));
    // R8: an idle boundary holds the line and the stored level
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> ($stable(line_out) && $stable(regs_q.held_lvl)));
endmodule

// File: tb/biphase_line_enc_tb.sv
module biphase_line_enc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_data = 1'b0;
    logic enc_mode = 1'b0;
    logic in_ready, line_out;

    int n_checks = 0;
    int n_fail = 0;

    logic  exp_q[$];
    string tag_q[$];

    logic m_held = 1'b0;
    logic m_line = 1'b0;
    logic m_code = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    biphase_line_enc dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .enc_mode (enc_mode),
        .in_ready (in_ready),
        .line_out (line_out)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: one expected line level per half-bit cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(line_out, e, t);
        end
    end

    task automatic send_bit(input logic x, input logic m);
        logic f, s;
        @(negedge clk);
        chk(in_ready, 1'b1, "R7 ready at boundary");
        in_valid = 1'b1;
        in_data  = x;
        enc_mode = m;
        if (m != m_code) m_held = 1'b0;   // R6 mode change clears
        if (m) begin                      // R2 mode 1 is Manchester, R3
            f = x;
            s = ~x;
        end else begin                    // R4 / R5 FM0
            f = ~m_held;
            s = x ? f : ~f;
        end
        m_held = m ? 1'b0 : s;
        m_code = m;
        m_line = s;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        chk(in_ready, 1'b0, "R7 busy after accept");
        exp_q.push_back(f);
        tag_q.push_back(m ? "R3 first half" : "R4 first half");
        exp_q.push_back(s);
        tag_q.push_back(m ? "R3 second half" : "R5 second half");
        @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = ~in_data;
            enc_mode = ~enc_mode;
            @(posedge clk);
            #1;
            exp_q.push_back(m_line);
            tag_q.push_back("R8 idle hold");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        chk(line_out, 1'b0, "R1 line low in reset");
        chk(in_ready, 1'b1, "R1 ready in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(line_out, 1'b0, "R1 line low after reset");
        // R6: first FM0 bit after reset starts high
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b0, 1'b0);
        idle(3);                          // R8
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b1);             // R2 R3 Manchester
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b0);             // R6 back to FM0: first half high
        send_bit(1'b0, 1'b0);
        idle(2);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b0);             // R6 after Manchester one (ends low)
        lfsr = 8'hA5;
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (lfsr[6:5] == 2'b00) idle(1);
            send_bit(lfsr[0], lfsr[2] & lfsr[1]);
        end
        idle(2);
        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule